// File: doc/BRIEF.md
# Serial Front-End Control Slave

This block is the bus-facing half of a small control slave on a two-wire serial link: a clock line and a bidirectional data line, in the style of the RF front-end control bus. The block oversamples both wires in its own faster system clock. It finds the sequence start condition, shifts in the command frame and checks odd parity on every frame. It then gives a register unit an address, write data and single-cycle write or read strobes. Three command types are decoded. The first is a compact write that carries seven data bits straight into register 0. The second is a full write with a 5-bit register address and an 8-bit data frame. The third is a read that returns an 8-bit data frame and its parity on the data line.

Writes are accepted when they are addressed to the unique slave ID, to the broadcast ID 0000 or to the programmed group ID. Reads are answered only on the unique ID. Each protocol fault is reported as its own one-cycle flag and is never dropped silently. The faults are a bad command parity, a bad data parity, a sequence cut short by a new start condition, a read sent to the broadcast or group ID, and an access to an address the register unit does not implement.

The register-unit side has no back-pressure. A strobe is a single-cycle event that the register unit must take in that cycle. `reg_addr_ok` and `reg_rdata` must be combinational functions of `reg_addr`.

Top module: `rffe_ctrl_slave`

## Requirements
- R1: A start condition is a rise and then a fall of SDATA while SCLK stays low. After it, bits are taken MSB first on falling SCLK edges. A write sequence is acted on when its 4-bit slave ID equals `usid`, equals 0000, or equals `gid`. Any other ID gives no strobe and no flag.
- R2: A compact write has the slave ID, a 1 bit, seven data bits and odd parity over those 12 bits. It pulses `reg_wr` with `reg_addr` = 0 and `reg_wdata` = {0, D6..D0}, three system clocks after the parity bit's falling SCLK edge.
- R3: A full write has the slave ID, command 010, address A4..A0, a parity bit, eight data bits D7..D0 and a data parity bit. If the address is implemented, it pulses `reg_wr` with that address and data three system clocks after the data parity edge. If the address is not implemented, it pulses `err_wr_unused` instead and gives no strobe.
- R4: A read uses command 011 on the unique ID. It pulses `reg_rd` three system clocks after the command parity edge. After the master's bus-park cycle, the slave drives D7..D0 and then odd parity, one bit per SCLK rising edge. It then drives 0 for its own park cycle and releases `sdata_oe` after the falling edge of that park cycle.
- R5: A command frame whose parity is even pulses `err_cmd_parity`. The rest of that sequence is ignored: no strobe and no register change.
- R6: A data frame whose parity is even pulses `err_data_parity` and gives no write strobe.
- R7: A start condition that arrives before the current sequence has ended pulses `err_length`. The new sequence is then decoded normally.
- R8: A read sent to ID 0000 or to `gid` (when that is not `usid`) pulses `err_bcast_read`. The data line is not driven.
- R9: A read of an unimplemented address pulses `err_rd_unused` and gives no `reg_rd`. It returns data 0x00 with parity 1.
- R10: After reset, every strobe, flag and `sdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial bus clock |
| sdata_in | input | 1 | Serial data line as seen at the pad |
| sdata_out | output | 1 | Data driven by the slave during a read |
| sdata_oe | output | 1 | High while the slave drives the data line |
| usid | input | 4 | Unique slave ID |
| gid | input | 4 | Group slave ID |
| reg_addr | output | 5 | Register address for the register unit |
| reg_wdata | output | 8 | Write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` |
| reg_addr_ok | input | 1 | High when `reg_addr` is implemented |
| err_cmd_parity | output | 1 | Command frame parity fault pulse |
| err_data_parity | output | 1 | Data frame parity fault pulse |
| err_length | output | 1 | Sequence cut short pulse |
| err_bcast_read | output | 1 | Read on broadcast or group ID pulse |
| err_rd_unused | output | 1 | Read of unimplemented address pulse |
| err_wr_unused | output | 1 | Write to unimplemented address pulse |

## Verification
Every strobe and flag that results from a falling SCLK edge is due exactly three system clocks after the bench drives that edge: two synchroniser stages, then one decoder register. The bench records the cycle of each bit edge it drives and the cycle in which each output pulse appears, and checks that the difference is three. Read data bits appear three clocks after an SCLK rising edge. The bench therefore samples each one near the end of the half-speed high phase. After the park edge it samples once more, well after the falling edge, to see the line released. Ignored sequences are checked by counting every strobe, flag and driven cycle over the whole sequence and reading the register back afterwards.

// File: rtl/rffe_pkg.sv
package rffe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_WDATA, ST_WPARK, ST_RPARK, ST_RDRV, ST_RSPARK, ST_SKIP
  } seq_state_e;

  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_WRITE = 3'b010;
  localparam logic [CMD_W-1:0] CMD_READ  = 3'b011;
endpackage

// File: rtl/rffe_bus_sampler.sv
module rffe_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic bit_o,
  output logic ssc_o
);
  logic [STAGES-1:0] ck_sh, da_sh;
  logic ck_q, da_q, armed;
  logic ck, da;

  assign ck = ck_sh[STAGES-1];
  assign da = da_sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_sh <= '0;
      da_sh <= '0;
      ck_q  <= 1'b0;
      da_q  <= 1'b0;
      armed <= 1'b0;
    end else begin
      ck_sh <= {ck_sh[STAGES-2:0], sclk_i};
      da_sh <= {da_sh[STAGES-2:0], sdata_i};
      ck_q  <= ck;
      da_q  <= da;
      // a data rise with the clock low arms the start detector
      if (ck || ssc_o) armed <= 1'b0;
      else if (da && !da_q) armed <= 1'b1;
    end
  end

  assign sclk_rise = ck && !ck_q;
  assign sclk_fall = !ck && ck_q;
  assign bit_o     = da;
  assign ssc_o     = !ck && !da && da_q && armed;
endmodule

// File: rtl/rffe_seq_decoder.sv
module rffe_seq_decoder
  import rffe_pkg::*;
#(
  parameter int SA_W   = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              ssc,
  input  logic              bit_i,
  input  logic [SA_W-1:0]   usid,
  input  logic [SA_W-1:0]   gid,
  input  logic              addr_ok,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic              err_cp,
  output logic              err_dp,
  output logic              err_len,
  output logic              err_bg,
  output logic              err_ru,
  output logic              err_wu,
  output logic              sd_out,
  output logic              sd_oe
);
  localparam int P_CMD = SA_W + CMD_W + ADDR_W;
  localparam int P_R0  = SA_W + DATA_W;
  localparam int SH_W  = (P_CMD > P_R0) ? P_CMD : P_R0;
  localparam int CMAX  = (SH_W > DATA_W + 1) ? SH_W : DATA_W + 1;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] C_SA    = CNT_W'(SA_W);
  localparam logic [CNT_W-1:0] C_PCMD  = CNT_W'(P_CMD);
  localparam logic [CNT_W-1:0] C_PR0   = CNT_W'(P_R0);
  localparam logic [CNT_W-1:0] C_ALAST = CNT_W'(P_CMD - 1);
  localparam logic [CNT_W-1:0] C_PDAT  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] C_PARK  = CNT_W'(DATA_W + 1);

  seq_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-1:0]   sh;
  logic [DATA_W:0]   tx;
  logic              par, is_r0;

  logic [SA_W-1:0]   sa_c;
  logic [CMD_W-1:0]  cmd_c;
  logic [DATA_W-1:0] rdv;
  logic              hit_u, hit_b, hit_g, wr_hit, par_good, at_cpar;

  assign sa_c     = is_r0 ? sh[P_R0-1 -: SA_W] : sh[P_CMD-1 -: SA_W];
  assign cmd_c    = sh[P_CMD-1-SA_W -: CMD_W];
  assign hit_u    = (sa_c == usid);
  assign hit_b    = (sa_c == '0);
  assign hit_g    = (sa_c == gid);
  assign wr_hit   = hit_u || hit_b || hit_g;
  assign par_good = par ^ bit_i;
  assign at_cpar  = (cnt > C_SA) && (cnt == (is_r0 ? C_PR0 : C_PCMD));
  assign rdv      = addr_ok ? rdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; par <= 1'b0; is_r0 <= 1'b0;
      reg_addr <= '0; reg_wdata <= '0; wr_stb <= 1'b0; rd_stb <= 1'b0;
      err_cp <= 1'b0; err_dp <= 1'b0; err_len <= 1'b0; err_bg <= 1'b0;
      err_ru <= 1'b0; err_wu <= 1'b0; sd_out <= 1'b0; sd_oe <= 1'b0;
    end else begin
      wr_stb <= 1'b0; rd_stb <= 1'b0;
      err_cp <= 1'b0; err_dp <= 1'b0; err_len <= 1'b0;
      err_bg <= 1'b0; err_ru <= 1'b0; err_wu <= 1'b0;
      if (ssc) begin
        // restart: any unfinished sequence is a length fault
        err_len <= (st != ST_IDLE) && (st != ST_SKIP);
        st <= ST_HDR; cnt <= '0; par <= 1'b0; sh <= '0; is_r0 <= 1'b0;
        sd_oe <= 1'b0; sd_out <= 1'b0;
      end else if (rise && st == ST_RDRV) begin
        sd_oe <= 1'b1;
        if (cnt == C_PARK) begin
          sd_out <= 1'b0;
          st <= ST_RSPARK;
        end else begin
          sd_out <= tx[DATA_W];
          tx <= {tx[DATA_W-1:0], 1'b0};
          cnt <= cnt + 1'b1;
        end
      end else if (fall) begin
        unique case (st)
          ST_HDR: begin
            if (at_cpar) begin
              if (!par_good) begin
                err_cp <= 1'b1; st <= ST_SKIP;
              end else if (is_r0) begin
                wr_stb <= wr_hit;
                reg_wdata <= {1'b0, sh[DATA_W-2:0]};
                st <= wr_hit ? ST_WPARK : ST_SKIP;
              end else if (cmd_c == CMD_WRITE && wr_hit) begin
                st <= ST_WDATA; cnt <= '0; par <= 1'b0;
              end else if (cmd_c == CMD_READ && hit_u) begin
                rd_stb <= addr_ok; err_ru <= !addr_ok;
                tx <= {rdv, ~^rdv};
                st <= ST_RPARK;
              end else begin
                err_bg <= (cmd_c == CMD_READ) && (hit_b || hit_g);
                st <= ST_SKIP;
              end
            end else begin
              sh <= {sh[SH_W-2:0], bit_i};
              par <= par ^ bit_i;
              cnt <= cnt + 1'b1;
              if (cnt == C_SA) begin
                is_r0 <= bit_i;
                if (bit_i) reg_addr <= '0;
              end
              if (!is_r0 && cnt == C_ALAST) reg_addr <= {sh[ADDR_W-2:0], bit_i};
            end
          end
          ST_WDATA: begin
            if (cnt == C_PDAT) begin
              if (!par_good) err_dp <= 1'b1;
              else if (addr_ok) begin
                wr_stb <= 1'b1; reg_wdata <= sh[DATA_W-1:0];
              end else err_wu <= 1'b1;
              st <= ST_WPARK;
            end else begin
              sh <= {sh[SH_W-2:0], bit_i};
              par <= par ^ bit_i;
              cnt <= cnt + 1'b1;
            end
          end
          ST_WPARK:  st <= ST_IDLE;
          ST_RPARK:  begin st <= ST_RDRV; cnt <= '0; end
          ST_RSPARK: begin sd_oe <= 1'b0; st <= ST_IDLE; end
          default:   ;
        endcase
      end
    end
  end

  assert_wr_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(fall));
  assert_rd_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> $past(fall));
  assert_len_on_ssc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |-> $past(ssc));
  assert_drive_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> $past(rise));
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_oe) |-> ($past(fall) || $past(ssc)));
  assert_one_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_cp, err_dp, err_len, err_bg, err_ru, err_wu}));
endmodule

// File: rtl/rffe_ctrl_slave.sv
module rffe_ctrl_slave #(
  parameter int SA_W        = 4,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  input  logic [SA_W-1:0]   usid,
  input  logic [SA_W-1:0]   gid,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_addr_ok,
  output logic              err_cmd_parity,
  output logic              err_data_parity,
  output logic              err_length,
  output logic              err_bcast_read,
  output logic              err_rd_unused,
  output logic              err_wr_unused
);
  logic rise, fall, bit_s, ssc;

  rffe_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata_in),
    .sclk_rise(rise), .sclk_fall(fall), .bit_o(bit_s), .ssc_o(ssc)
  );

  rffe_seq_decoder #(.SA_W(SA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decoder (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .ssc(ssc), .bit_i(bit_s),
    .usid(usid), .gid(gid), .addr_ok(reg_addr_ok), .rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .wr_stb(reg_wr), .rd_stb(reg_rd),
    .err_cp(err_cmd_parity), .err_dp(err_data_parity), .err_len(err_length),
    .err_bg(err_bcast_read), .err_ru(err_rd_unused), .err_wu(err_wr_unused),
    .sd_out(sdata_out), .sd_oe(sdata_oe)
  );
endmodule

// File: tb/test_rffe_ctrl_slave.sv
module test_rffe_ctrl_slave;
  localparam int CLK_P = 10;
  localparam int WH = 4;
  localparam int RH = 8;
  localparam int LAT = 3;
  localparam logic [3:0] MY_ID = 4'b1010;
  localparam logic [3:0] GRP_ID = 4'b0011;

  logic clk = 0, rst_n = 0, sclk = 0, m_sda = 0;
  logic sdata_out, sdata_oe, reg_wr, reg_rd;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic reg_addr_ok;
  logic e_cp, e_dp, e_len, e_bg, e_ru, e_wu;
  logic sdata_in;
  logic [7:0] regs_q [0:31];

  assign sdata_in = sdata_oe ? sdata_out : m_sda;
  assign reg_addr_ok = (reg_addr == 5'h00) || (reg_addr == 5'h01) || (reg_addr == 5'h1C);
  assign reg_rdata = regs_q[reg_addr];

  always #(CLK_P/2) clk = ~clk;

  rffe_ctrl_slave i_rffe_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .usid(MY_ID), .gid(GRP_ID),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .reg_addr_ok(reg_addr_ok),
    .err_cmd_parity(e_cp), .err_data_parity(e_dp), .err_length(e_len),
    .err_bcast_read(e_bg), .err_rd_unused(e_ru), .err_wr_unused(e_wu)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) regs_q[i] <= 8'h00;
    end else if (reg_wr && reg_addr_ok) regs_q[reg_addr] <= reg_wdata;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int n_wr, n_rd, n_cp, n_dp, n_len, n_bg, n_ru, n_wu, n_oe;
  int wr_cyc, rd_cyc, err_cyc, pfall;
  logic [4:0] wr_a;
  logic [7:0] wr_d;

  always @(negedge clk) if (rst_n) begin
    if (reg_wr) begin n_wr++; wr_a = reg_addr; wr_d = reg_wdata; wr_cyc = cyc; end
    if (reg_rd) begin n_rd++; rd_cyc = cyc; end
    if (e_cp)  begin n_cp++;  err_cyc = cyc; end
    if (e_dp)  begin n_dp++;  err_cyc = cyc; end
    if (e_len) n_len++;
    if (e_bg)  begin n_bg++;  err_cyc = cyc; end
    if (e_ru)  begin n_ru++;  err_cyc = cyc; end
    if (e_wu)  begin n_wu++;  err_cyc = cyc; end
    if (sdata_oe) n_oe++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_wr = 0; n_rd = 0; n_cp = 0; n_dp = 0; n_len = 0; n_bg = 0;
    n_ru = 0; n_wu = 0; n_oe = 0; wr_cyc = 0; rd_cyc = 0; err_cyc = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ssc();
    @(negedge clk); m_sda = 0; wait_n(3);
    m_sda = 1; wait_n(3);
    m_sda = 0; wait_n(3);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sclk = 1; m_sda = b;
    wait_n(WH);
    sclk = 0; pfall = cyc;
    wait_n(WH - 1);
  endtask

  task automatic send_vec(input logic [11:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic seq_wr0(input logic [3:0] sa, input logic [6:0] d);
    logic [11:0] h;
    h = {sa, 1'b1, d};
    ssc(); send_vec(h, 12); send_bit(~^h); send_bit(1'b0);
    wait_n(10);
  endtask

  task automatic seq_wr(input logic [3:0] sa, input logic [4:0] a, input logic [7:0] d,
                        input bit bad_c, input bit bad_d, output int pf);
    logic [11:0] h;
    h = {sa, 3'b010, a};
    ssc(); send_vec(h, 12); send_bit((~^h) ^ bad_c);
    send_vec({4'h0, d}, 8); send_bit((~^d) ^ bad_d);
    pf = pfall;
    send_bit(1'b0);
    wait_n(10);
  endtask

  task automatic seq_rd(input logic [3:0] sa, input logic [4:0] a,
                        output logic [8:0] got, output logic park_ok,
                        output logic oe_after, output int pf);
    logic [11:0] h;
    h = {sa, 3'b011, a};
    ssc(); send_vec(h, 12); send_bit(~^h); pf = pfall; send_bit(1'b0);
    for (int i = 8; i >= 0; i--) begin
      @(negedge clk); sclk = 1; m_sda = 0;
      wait_n(RH);
      got[i] = sdata_oe & sdata_out;
      sclk = 0; wait_n(RH);
    end
    @(negedge clk); sclk = 1; wait_n(RH);
    park_ok = sdata_oe && !sdata_out;
    sclk = 0; wait_n(RH);
    oe_after = sdata_oe;
    wait_n(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [8:0] got;
    logic pk, oa;
    int pf;
    clr();
    wait_n(5); rst_n = 1; wait_n(5);
    // R10 reset state
    chk("R10 outputs idle after reset",
        {28'd0, reg_wr, reg_rd, sdata_oe, e_cp | e_dp | e_len | e_bg | e_ru | e_wu}, 0);

    // R2 compact write on unique ID
    clr(); seq_wr0(MY_ID, 7'h55);
    chk("R2 wr count", n_wr, 1); chk("R2 addr", wr_a, 0); chk("R2 data", wr_d, 8'h55);
    clr(); seq_wr0(MY_ID, 7'h02);
    chk("R2 data second", wr_d, 8'h02);

    // R3 full write with latency
    clr(); seq_wr(MY_ID, 5'h01, 8'hA7, 0, 0, pf);
    chk("R3 wr count", n_wr, 1); chk("R3 addr", wr_a, 1); chk("R3 data", wr_d, 8'hA7);
    chk("R3 latency", wr_cyc - pf, LAT);

    // R1 broadcast and group writes accepted, foreign ignored
    clr(); seq_wr(4'b0000, 5'h1C, 8'h3C, 0, 0, pf);
    chk("R1 broadcast wr", n_wr, 1); chk("R1 broadcast data", wr_d, 8'h3C);
    clr(); seq_wr(GRP_ID, 5'h01, 8'h0F, 0, 0, pf);
    chk("R1 group wr", n_wr, 1); chk("R1 group addr", wr_a, 1);
    clr(); seq_wr(4'b0101, 5'h01, 8'hEE, 0, 0, pf);
    chk("R1 foreign no strobe", n_wr + n_cp + n_dp + n_wu + n_bg, 0);
    clr(); seq_wr0(4'b0110, 7'h11);
    chk("R1 foreign compact ignored", n_wr, 0);

    // R4 reads
    clr(); seq_rd(MY_ID, 5'h01, got, pk, oa, pf);
    chk("R4 rd strobe", n_rd, 1); chk("R4 rd latency", rd_cyc - pf, LAT);
    chk("R4 data+parity addr1", got, {8'h0F, 1'b1});
    chk("R4 park driven low", pk, 1); chk("R4 released", oa, 0);
    clr(); seq_rd(MY_ID, 5'h00, got, pk, oa, pf);
    chk("R4 data+parity addr0", got, {8'h02, 1'b0});
    clr(); seq_rd(MY_ID, 5'h1C, got, pk, oa, pf);
    chk("R4 data+parity addr1C", got, {8'h3C, 1'b1});

    // R3 write to unused address
    clr(); seq_wr(MY_ID, 5'h05, 8'h99, 0, 0, pf);
    chk("R3 unused no strobe", n_wr, 0); chk("R3 unused flag", n_wu, 1);
    chk("R3 unused flag latency", err_cyc - pf, LAT);

    // R9 read of unused address
    clr(); seq_rd(MY_ID, 5'h05, got, pk, oa, pf);
    chk("R9 rd unused flag", n_ru, 1); chk("R9 no rd strobe", n_rd, 0);
    chk("R9 zero data parity 1", got, 9'h001);

    // R5 command parity error ignored
    clr(); seq_wr(MY_ID, 5'h01, 8'h44, 1, 0, pf);
    chk("R5 cmd parity flag", n_cp, 1); chk("R5 no strobe", n_wr + n_dp, 0);
    clr(); seq_rd(MY_ID, 5'h01, got, pk, oa, pf);
    chk("R5 register unchanged", got, {8'h0F, 1'b1});

    // R6 data parity error
    clr(); seq_wr(MY_ID, 5'h01, 8'h66, 0, 1, pf);
    chk("R6 data parity flag", n_dp, 1); chk("R6 no strobe", n_wr, 0);
    chk("R6 flag latency", err_cyc - pf, LAT);

    // R8 reads on broadcast and group IDs
    clr(); seq_rd(4'b0000, 5'h01, got, pk, oa, pf);
    chk("R8 broadcast read flag", n_bg, 1); chk("R8 line not driven", n_oe, 0);
    clr(); seq_rd(GRP_ID, 5'h01, got, pk, oa, pf);
    chk("R8 group read flag", n_bg, 1); chk("R8 no rd strobe", n_rd + n_oe, 0);

    // R7 truncated sequence then a full write
    clr(); ssc(); send_vec(12'h02A, 6);
    seq_wr(MY_ID, 5'h1C, 8'h81, 0, 0, pf);
    chk("R7 length flag", n_len, 1); chk("R7 following write", n_wr, 1);
    chk("R7 following data", wr_d, 8'h81);
    clr(); seq_wr0(MY_ID, 7'h33);
    chk("R7 no length flag on clean run", n_len, 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule